// File: doc/BRIEF.md
# Sign-Magnitude Accumulator Adder with Sticky Overflow

This unit adds an operand to an accumulator value, or subtracts it, where both are held as a separate sign bit and an unsigned magnitude. A word magnitude is five bytes of six bits, so 30 bits by default. The caller presents the current accumulator and the operand together with an operation strobe. One clock later the unit returns the new accumulator sign and magnitude. A sticky overflow toggle records every word-mode result whose magnitude did not fit.

A second mode works on two-byte index quantities. In this mode only the low two bytes of each magnitude take part. The result wraps within two bytes and leaves the overflow toggle alone. A jump-on-overflow action reads the toggle and turns it off in one go. It reads the flag output and pulses the clear input in the same cycle.

Top module: `smas_unit`

## Requirements
- R1: With equal effective signs in word mode, the result magnitude is the sum of both magnitudes and the result sign is the accumulator sign (0 = plus, 1 = minus).
- R2: With differing effective signs, the smaller magnitude is taken from the larger. The result takes the sign of the operand with the larger magnitude.
- R3: When op_sub is 1, the unit behaves exactly as an add with the operand sign inverted.
- R4: In word mode, a sum of 2^30 or more keeps only the sum modulo 2^30 as the magnitude and sets the overflow toggle.
- R5: An operation without overflow leaves the toggle as it was. Add and subtract never clear it.
- R6: A zero result magnitude carries the accumulator's prior sign, so both minus zero and plus zero appear.
- R7: A pulse on ovf_clr turns the toggle off from the next cycle. If an overflowing operation falls in the same cycle, the toggle ends up on.
- R8: When idx_mode is 1, only magnitude bits 11:0 of both inputs are used. The result magnitude wraps modulo 2^12, bits 29:12 of the result are zero, and the toggle does not change.
- R9: Reset, whether at start or in mid-run, gives res_valid 0, a plus-zero result and the toggle off.
- R10: The result registers load one cycle after op_valid, and res_valid pulses in that cycle. Without op_valid the result holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Perform an operation this cycle |
| op_sub | input | 1 | 1 = subtract operand, 0 = add |
| idx_mode | input | 1 | 1 = two-byte index arithmetic |
| acc_sign | input | 1 | Accumulator sign, 1 = minus |
| acc_mag | input | 30 | Accumulator magnitude |
| v_sign | input | 1 | Operand sign, 1 = minus |
| v_mag | input | 30 | Operand magnitude |
| ovf_clr | input | 1 | Turn the overflow toggle off |
| res_valid | output | 1 | Result updated this cycle |
| res_sign | output | 1 | New accumulator sign |
| res_mag | output | 30 | New accumulator magnitude |
| ovf_flag | output | 1 | Sticky overflow toggle |

## Verification
The arithmetic is tried with several operand pairs:
- Pairs with matching signs, and pairs with opposite signs where either side is larger. These tell the add path from the larger-minus-smaller path.
- Subtracts where inverting the operand sign flips which path is taken.
- Sums just across 2^30, and an exact 2^30 sum that wraps to zero. These separate the kept remainder from the carry.
- Equal magnitudes with opposite signs, and minus-zero inputs. These show which sign a zero result gets.

Index-mode vectors carry garbage above bit 11 and carry out of bit 11. Directed sequences then pit stickiness, clearing and a clear in the same cycle as an overflow against one another.

// File: rtl/smas_pkg.sv
// Shared encodings for the sign-magnitude add/subtract unit.
// Assumes sign bit 1 means minus; magnitudes are plain unsigned vectors.
package smas_pkg;

    typedef enum logic {
        SGN_PLUS  = 1'b0,
        SGN_MINUS = 1'b1
    } sgn_e;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

    // Result of the magnitude datapath before registering
    typedef struct packed {
        logic sign;
        logic carry;
        logic same_sign;
    } dp_flags_t;

endpackage

// File: rtl/smas_operand_prep.sv
// Operand preparation: masks magnitudes to the active width byte by byte
// and folds the subtract select into the operand sign.
// Assumes MAG_W = BYTE_W*WORD_BYTES and IDX_BYTES <= WORD_BYTES.
module smas_operand_prep #(
    parameter int BYTE_W     = 6,
    parameter int WORD_BYTES = 5,
    parameter int IDX_BYTES  = 2,
    localparam int MAG_W     = BYTE_W * WORD_BYTES
) (
    input  logic             idx_mode,
    input  logic             op_sub,
    input  logic [MAG_W-1:0] acc_mag,
    input  logic             v_sign,
    input  logic [MAG_W-1:0] v_mag,
    output logic [MAG_W-1:0] a_mag,
    output logic [MAG_W-1:0] b_mag,
    output logic             b_sign
);
    import smas_pkg::*;

    logic [MAG_W-1:0] keep_mask;

    // One byte lane per generate iteration: low index bytes always kept
    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
        if (g < IDX_BYTES) begin : g_idx_lane
            assign keep_mask[g*BYTE_W +: BYTE_W] = {BYTE_W{1'b1}};
        end else begin : g_word_lane
            assign keep_mask[g*BYTE_W +: BYTE_W] = {BYTE_W{~idx_mode}};
        end
    end

    // Apply lane mask and invert operand sign for subtract
    always_comb begin
        a_mag  = acc_mag & keep_mask;
        b_mag  = v_mag & keep_mask;
        b_sign = (op_e'(op_sub) == OP_SUB) ? ~v_sign : v_sign;
    end

endmodule

// File: rtl/smas_mag_datapath.sv
// Magnitude datapath: sum for matching signs, larger-minus-smaller for
// differing signs, sign selection with the zero-keeps-sign rule.
// Assumes masked inputs; carry is the bit just above the word magnitude.
module smas_mag_datapath #(
    parameter int BYTE_W     = 6,
    parameter int WORD_BYTES = 5,
    parameter int IDX_BYTES  = 2,
    localparam int MAG_W     = BYTE_W * WORD_BYTES,
    localparam int IDX_W     = BYTE_W * IDX_BYTES
) (
    input  logic                idx_mode,
    input  logic                a_sign,
    input  logic [MAG_W-1:0]    a_mag,
    input  logic                b_sign,
    input  logic [MAG_W-1:0]    b_mag,
    output logic [MAG_W-1:0]    r_mag,
    output smas_pkg::dp_flags_t r_flags
);
    import smas_pkg::*;

    logic [MAG_W:0]   sum_ext;
    logic [MAG_W-1:0] diff_ab;
    logic [MAG_W-1:0] diff_ba;
    logic             a_ge_b;
    logic             same;
    logic [MAG_W-1:0] raw_mag;
    logic [MAG_W-1:0] idx_keep;

    assign idx_keep = {{(MAG_W-IDX_W){1'b0}}, {IDX_W{1'b1}}};

    // Both candidate magnitudes and the ordering of the inputs
    always_comb begin
        sum_ext = {1'b0, a_mag} + {1'b0, b_mag};
        diff_ab = a_mag - b_mag;
        diff_ba = b_mag - a_mag;
        a_ge_b  = (a_mag >= b_mag);
        same    = (a_sign == b_sign);
    end

    // Select magnitude and sign; wrap to the active width
    always_comb begin
        if (same) begin
            raw_mag = sum_ext[MAG_W-1:0];
        end else if (a_ge_b) begin
            raw_mag = diff_ab;
        end else begin
            raw_mag = diff_ba;
        end
        r_mag = idx_mode ? (raw_mag & idx_keep) : raw_mag;

        r_flags.same_sign = same;
        r_flags.carry     = same & sum_ext[MAG_W] & ~idx_mode;
        if (r_mag == '0) begin
            r_flags.sign = a_sign;
        end else if (same || a_ge_b) begin
            r_flags.sign = a_sign;
        end else begin
            r_flags.sign = b_sign;
        end
    end

endmodule

// File: rtl/smas_ovf_toggle.sv
// Sticky overflow toggle: set by an overflow event, cleared by a strobe.
// Assumes a set and clear in the same cycle resolve in favour of set.
module smas_ovf_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic clr,
    output logic flag
);
    // Hold, set or clear the toggle each cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_ev) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/smas_unit.sv
// Sign-magnitude add/subtract unit with registered result and sticky
// overflow toggle. Word mode uses BYTE_W*WORD_BYTES magnitude bits, index
// mode uses BYTE_W*IDX_BYTES bits and never touches the toggle.
// Assumes callers feed back res_* as the next accumulator if desired.
module smas_unit #(
    parameter int BYTE_W     = 6,
    parameter int WORD_BYTES = 5,
    parameter int IDX_BYTES  = 2,
    localparam int MAG_W     = BYTE_W * WORD_BYTES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic             op_sub,
    input  logic             idx_mode,
    input  logic             acc_sign,
    input  logic [MAG_W-1:0] acc_mag,
    input  logic             v_sign,
    input  logic [MAG_W-1:0] v_mag,
    input  logic             ovf_clr,
    output logic             res_valid,
    output logic             res_sign,
    output logic [MAG_W-1:0] res_mag,
    output logic             ovf_flag
);
    import smas_pkg::*;

    logic [MAG_W-1:0] a_mag;
    logic [MAG_W-1:0] b_mag;
    logic             b_sign;
    logic [MAG_W-1:0] nxt_mag;
    dp_flags_t        nxt_flags;
    logic             ovf_event;

    smas_operand_prep #(
        .BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES), .IDX_BYTES(IDX_BYTES)
    ) u_prep (
        .idx_mode (idx_mode),
        .op_sub   (op_sub),
        .acc_mag  (acc_mag),
        .v_sign   (v_sign),
        .v_mag    (v_mag),
        .a_mag    (a_mag),
        .b_mag    (b_mag),
        .b_sign   (b_sign)
    );

    smas_mag_datapath #(
        .BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES), .IDX_BYTES(IDX_BYTES)
    ) u_dp (
        .idx_mode (idx_mode),
        .a_sign   (acc_sign),
        .a_mag    (a_mag),
        .b_sign   (b_sign),
        .b_mag    (b_mag),
        .r_mag    (nxt_mag),
        .r_flags  (nxt_flags)
    );

    assign ovf_event = op_valid & nxt_flags.carry;

    smas_ovf_toggle u_ovf (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (ovf_event),
        .clr    (ovf_clr),
        .flag   (ovf_flag)
    );

    // Result registers: load on an operation, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_sign  <= SGN_PLUS;
            res_mag   <= '0;
        end else begin
            res_valid <= op_valid;
            if (op_valid) begin
                res_sign <= nxt_flags.sign;
                res_mag  <= nxt_mag;
            end
        end
    end

endmodule

// File: rtl/smas_unit_chk.sv
// Property checker for smas_unit, attached by bind below.
// Assumes the same parameters as the unit it observes.
module smas_unit_chk #(
    parameter int BYTE_W     = 6,
    parameter int WORD_BYTES = 5,
    parameter int IDX_BYTES  = 2,
    localparam int MAG_W     = BYTE_W * WORD_BYTES,
    localparam int IDX_W     = BYTE_W * IDX_BYTES
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic             idx_mode,
    input logic             acc_sign,
    input logic             ovf_clr,
    input logic             res_valid,
    input logic             res_sign,
    input logic [MAG_W-1:0] res_mag,
    input logic             ovf_flag
);
    // R5: the toggle stays on unless cleared
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag && !ovf_clr |=> ovf_flag);

    // R7: a clear with no operation turns the toggle off
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_clr && !op_valid |=> !ovf_flag);

    // R8: index operations leave the toggle unchanged
    a_r8_idx_keeps_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && idx_mode && !ovf_clr |=> $stable(ovf_flag));

    // R8: index results have no bits above the two-byte field
    a_r8_idx_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && idx_mode |=> (res_mag >> IDX_W) == '0);

    // R6: a zero result carries the prior accumulator sign
    a_r6_zero_sign: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (res_mag != '0) || (res_sign == $past(acc_sign)));

    // R10: result valid pulses one cycle after an operation
    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);

    // R10: without an operation the result holds
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !res_valid && $stable(res_mag) && $stable(res_sign));

endmodule

bind smas_unit smas_unit_chk #(
    .BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES), .IDX_BYTES(IDX_BYTES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .idx_mode  (idx_mode),
    .acc_sign  (acc_sign),
    .ovf_clr   (ovf_clr),
    .res_valid (res_valid),
    .res_sign  (res_sign),
    .res_mag   (res_mag),
    .ovf_flag  (ovf_flag)
);

// File: tb/smas_unit_tb_top.sv
// Self-checking bench: vector table walked by one loop, then directed tests.
module smas_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MW = 30;
    localparam int NV = 19;

    typedef struct packed {
        logic          sub;
        logic          idx;
        logic          as_;
        logic [MW-1:0] am;
        logic          vs;
        logic [MW-1:0] vm;
        logic          es;
        logic [MW-1:0] em;
        logic          eo;
        logic [7:0]    req;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,30'd100,       1'b0,30'd23,        1'b0,30'd123,       1'b0,8'd1}, // R1
        '{1'b0,1'b0,1'b1,30'd500,       1'b1,30'd20,        1'b1,30'd520,       1'b0,8'd1}, // R1
        '{1'b0,1'b0,1'b0,30'd100,       1'b1,30'd30,        1'b0,30'd70,        1'b0,8'd2}, // R2
        '{1'b0,1'b0,1'b0,30'd30,        1'b1,30'd100,       1'b1,30'd70,        1'b0,8'd2}, // R2
        '{1'b1,1'b0,1'b0,30'd100,       1'b0,30'd30,        1'b0,30'd70,        1'b0,8'd3}, // R3
        '{1'b1,1'b0,1'b0,30'd30,        1'b0,30'd100,       1'b1,30'd70,        1'b0,8'd3}, // R3
        '{1'b1,1'b0,1'b1,30'd5,         1'b1,30'd7,         1'b0,30'd2,         1'b0,8'd3}, // R3
        '{1'b0,1'b0,1'b0,30'h3FFFFFFF,  1'b0,30'd1,         1'b0,30'd0,         1'b1,8'd4}, // R4
        '{1'b0,1'b0,1'b1,30'h3FFFFFFF,  1'b1,30'd5,         1'b1,30'd4,         1'b1,8'd4}, // R4
        '{1'b1,1'b0,1'b0,30'h3FFFFFFF,  1'b1,30'd2,         1'b0,30'd1,         1'b1,8'd4}, // R4
        '{1'b0,1'b0,1'b1,30'h20000000,  1'b1,30'h20000000,  1'b1,30'd0,         1'b1,8'd6}, // R6
        '{1'b0,1'b0,1'b1,30'd50,        1'b0,30'd50,        1'b1,30'd0,         1'b0,8'd6}, // R6
        '{1'b1,1'b0,1'b0,30'd50,        1'b0,30'd50,        1'b0,30'd0,         1'b0,8'd6}, // R6
        '{1'b0,1'b0,1'b1,30'd0,         1'b0,30'd0,         1'b1,30'd0,         1'b0,8'd6}, // R6
        '{1'b0,1'b1,1'b0,30'hFA0,       1'b0,30'h100,       1'b0,30'h0A0,       1'b0,8'd8}, // R8
        '{1'b0,1'b1,1'b0,30'h3FFFF005,  1'b0,30'h3,         1'b0,30'h008,       1'b0,8'd8}, // R8
        '{1'b0,1'b1,1'b0,30'h010,       1'b1,30'h020,       1'b1,30'h010,       1'b0,8'd8}, // R8
        '{1'b0,1'b1,1'b0,30'h3FFFF000,  1'b1,30'h00ABC000,  1'b0,30'h0,         1'b0,8'd8}, // R8
        '{1'b0,1'b0,1'b1,30'h12345678,  1'b0,30'h02345678,  1'b1,30'h10000000,  1'b0,8'd2}  // R2
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic          op_sub = 1'b0;
    logic          idx_mode = 1'b0;
    logic          acc_sign = 1'b0;
    logic [MW-1:0] acc_mag = '0;
    logic          v_sign = 1'b0;
    logic [MW-1:0] v_mag = '0;
    logic          ovf_clr = 1'b0;
    logic          res_valid;
    logic          res_sign;
    logic [MW-1:0] res_mag;
    logic          ovf_flag;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smas_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sub(op_sub),
        .idx_mode(idx_mode), .acc_sign(acc_sign), .acc_mag(acc_mag),
        .v_sign(v_sign), .v_mag(v_mag), .ovf_clr(ovf_clr),
        .res_valid(res_valid), .res_sign(res_sign), .res_mag(res_mag),
        .ovf_flag(ovf_flag)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Apply one operation for one cycle; outputs are valid on return
    task automatic do_op(input logic sub, input logic idx, input logic as_,
                         input logic [MW-1:0] am, input logic vs,
                         input logic [MW-1:0] vm, input logic clr);
        @(negedge clk);
        op_valid = 1'b1; op_sub = sub; idx_mode = idx;
        acc_sign = as_; acc_mag = am; v_sign = vs; v_mag = vm; ovf_clr = clr;
        @(negedge clk);
        op_valid = 1'b0; ovf_clr = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check("R9 res_valid after reset", 64'(res_valid), 64'd0);
        check("R9 result after reset", {res_sign, res_mag}, 64'd0);
        check("R9 toggle after reset", 64'(ovf_flag), 64'd0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            pulse_clr();
            do_op(VECS[i].sub, VECS[i].idx, VECS[i].as_, VECS[i].am,
                  VECS[i].vs, VECS[i].vm, 1'b0);
            n_chk++;
            if ({res_sign, res_mag} !== {VECS[i].es, VECS[i].em}) begin
                n_fail++;
                $display("FAIL R%0d vec %0d result actual=%0h expected=%0h",
                         VECS[i].req, i, {res_sign, res_mag}, {VECS[i].es, VECS[i].em});
            end
            n_chk++;
            if (ovf_flag !== VECS[i].eo) begin
                n_fail++;
                $display("FAIL R%0d vec %0d toggle actual=%0h expected=%0h",
                         VECS[i].req, i, ovf_flag, VECS[i].eo);
            end
        end

        // R10: valid pulses with an operation
        do_op(1'b0, 1'b0, 1'b0, 30'd1, 1'b0, 30'd2, 1'b0);
        check("R10 res_valid after op", 64'(res_valid), 64'd1);
        // R10: inputs change without op_valid, result holds
        @(negedge clk);
        acc_mag = 30'd999; v_mag = 30'd1; acc_sign = 1'b1;
        @(negedge clk);
        check("R10 res_valid idle", 64'(res_valid), 64'd0);
        check("R10 result held", {res_sign, res_mag}, 64'd3);

        // R5: sticky toggle through a non-overflowing op
        pulse_clr();
        do_op(1'b0, 1'b0, 1'b0, 30'h3FFFFFFF, 1'b0, 30'd3, 1'b0);
        check("R4 toggle set", 64'(ovf_flag), 64'd1);
        do_op(1'b1, 1'b0, 1'b0, 30'd10, 1'b0, 30'd4, 1'b0);
        check("R5 toggle kept after add", 64'(ovf_flag), 64'd1);
        check("R5 result of later op", {res_sign, res_mag}, 64'd6);

        // R8: index op with two-byte carry keeps toggle set
        do_op(1'b0, 1'b1, 1'b0, 30'hFFF, 1'b0, 30'h1, 1'b0);
        check("R8 idx keeps toggle set", 64'(ovf_flag), 64'd1);
        check("R8 idx wrap result", {res_sign, res_mag}, 64'd0);

        // R7: test-and-clear
        pulse_clr();
        check("R7 toggle cleared", 64'(ovf_flag), 64'd0);
        // R8: index carry does not set the toggle
        do_op(1'b0, 1'b1, 1'b1, 30'hFFE, 1'b1, 30'h5, 1'b0);
        check("R8 idx no set", 64'(ovf_flag), 64'd0);
        check("R8 idx result", {res_sign, res_mag}, {1'b1, 30'h3});
        // R7: clear and overflow in the same cycle, set wins
        do_op(1'b0, 1'b0, 1'b1, 30'h30000000, 1'b1, 30'h10000000, 1'b1);
        check("R7 set beats clear", 64'(ovf_flag), 64'd1);
        check("R4 exact wrap result", {res_sign, res_mag}, {1'b1, 30'h0});

        // R9: mid-run reset
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 toggle after mid reset", 64'(ovf_flag), 64'd0);
        check("R9 result after mid reset", {res_sign, res_mag}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule